// File: doc/BRIEF.md
# Min max average accumulator

This block holds a 32-word scratch memory of unsigned `DATA_W`-bit values that a host fills through a synchronous write port. A start pulse makes it read every word once, in address order 0 to 31, while three reductions run side by side: the smallest value, the largest value and the total. At the end of the pass it forms the average by dropping the five low bits of the total, and it raises a done flag.

The three results stay in their registers until the next pass. A 2-bit select input chooses which result appears on the output bus, so the host can read all three after done without any handshake. Inside, a controller sequences the pass and a datapath holds the reductions. Writes and start pulses that arrive while a pass is running are dropped, so the data set and the pass timing cannot be disturbed.

Top module: `mma_accum`

## Requirements
- R1: After synchronous reset, `done` is 0 and `rd_data` reads 0 for every value of `rd_sel`.
- R2: When no pass is running, `wr_en` high on a rising edge stores `wr_data` into the word at the 5-bit address `wr_addr`, one of 32 words.
- R3: A `start` high on a rising edge with no pass running is accepted, and `done` is high from the 32nd rising edge after the accepting edge. It is low before that edge.
- R4: The minimum result is the smallest of the 32 words. The minimum register starts the pass at all ones and is replaced only by a strictly smaller word.
- R5: The maximum result is the largest of the 32 words. The maximum register starts the pass at 0 and is replaced only by a strictly larger word.
- R6: The total is held in `DATA_W+5` bits, so it never wraps. The average is the total divided by 32 with truncation, which is bits [DATA_W+4:5] of the total.
- R7: `rd_sel` = 2'b01 drives the minimum on `rd_data`, 2'b10 the maximum, 2'b11 the average, and 2'b00 drives zero.
- R8: `done` stays high until a start is accepted, and it is low after that accepting edge.
- R9: `wr_en` is ignored while a pass is running, and the memory content does not change.
- R10: `start` is ignored while a pass is running, and the pass finishes at its original time.
- R11: Every pass starts from fresh reduction registers, so its results depend only on the current memory content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store strobe for the scratch memory |
| wr_addr | input | 5 | Word address for the store |
| wr_data | input | DATA_W | Value to store |
| start | input | 1 | Pass request |
| done | output | 1 | High when the results of the last pass are valid |
| rd_sel | input | 2 | Result select: 01 minimum, 10 maximum, 11 average, 00 zero |
| rd_data | output | DATA_W | Selected result |

## Verification
On every cycle the assertions check the following: the minimum never rises and the maximum never falls during a pass, and the total never shrinks. The minimum does not exceed the maximum once done is high. Done holds until a start is accepted and drops after it. Start and write strobes during a pass leave the sequence and the memory untouched. Only the bench scenarios can show that the final values are the correct minimum, maximum and truncated average of the data loaded, and that the done flag rises at exactly the right edge. The scenarios cover all-zero and all-ones data, ramps, scattered data, data whose extremes sit at the first and last addresses, and totals just below and at a multiple of 32.

// File: rtl/mma_pkg.sv
package mma_pkg;
    localparam int MEM_WORDS = 32;
    localparam int ADDR_W    = $clog2(MEM_WORDS);
    localparam int AVG_SHIFT = $clog2(MEM_WORDS);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SEL_ZERO = 2'b00,
        SEL_MIN  = 2'b01,
        SEL_MAX  = 2'b10,
        SEL_AVG  = 2'b11
    } sel_e;

    function automatic logic [ADDR_W-1:0] last_index();
        return ADDR_W'(MEM_WORDS - 1);
    endfunction
endpackage

// File: rtl/mma_store.sv
module mma_store
    import mma_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_word
);
    logic [MEM_WORDS-1:0][DATA_W-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else if (wr_en && !busy) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_word = mem_q[rd_idx];

    // R9: the memory is frozen while a pass runs
    p_frozen_mem_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mem_q));
endmodule

// File: rtl/mma_ctrl.sv
module mma_ctrl
    import mma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              init,
    output logic              step,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] idx
);
    phase_e phase_q;
    logic [ADDR_W-1:0] idx_q;

    assign busy = (phase_q == PH_RUN);
    assign step = busy;
    assign init = start && !busy;
    assign done = (phase_q == PH_DONE);
    assign idx  = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_RUN: begin
                    if (idx_q == last_index()) begin
                        phase_q <= PH_DONE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: begin
                    if (start) begin
                        phase_q <= PH_RUN;
                        idx_q   <= '0;
                    end
                end
            endcase
        end
    end

    // R8: done holds until a start is accepted
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
    // R8: an accepted start clears done
    p_done_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> (!done && busy));
    // R10: a start during a pass neither restarts nor ends it early
    p_ignore_start_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && start && idx_q != last_index()) |=> (busy && idx_q != '0));
endmodule

// File: rtl/mma_reduce.sv
module mma_reduce
    import mma_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              step,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] min_o,
    output logic [DATA_W-1:0] max_o,
    output logic [DATA_W-1:0] avg_o
);
    localparam int SUM_W = DATA_W + AVG_SHIFT;

    logic [DATA_W-1:0] min_q, max_q;
    logic [SUM_W-1:0]  sum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            min_q <= '0;
            max_q <= '0;
            sum_q <= '0;
        end else if (init) begin
            min_q <= '1;
            max_q <= '0;
            sum_q <= '0;
        end else if (step) begin
            sum_q <= sum_q + SUM_W'(word);
            if (word < min_q) min_q <= word;
            if (word > max_q) max_q <= word;
        end
    end

    assign min_o = min_q;
    assign max_o = max_q;
    assign avg_o = sum_q[SUM_W-1:AVG_SHIFT];

    // R4: the running minimum never rises during a pass
    p_min_nonincr_r4: assert property (@(posedge clk) disable iff (rst)
        step |=> (min_q <= $past(min_q)));
    // R5: the running maximum never falls during a pass
    p_max_nondecr_r5: assert property (@(posedge clk) disable iff (rst)
        step |=> (max_q >= $past(max_q)));
    // R6: the total never wraps
    p_sum_grows_r6: assert property (@(posedge clk) disable iff (rst)
        step |=> (sum_q >= $past(sum_q)));
endmodule

// File: rtl/mma_accum.sv
module mma_accum
    import mma_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start,
    output logic              done,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    logic              init, step, busy;
    logic [ADDR_W-1:0] idx;
    logic [DATA_W-1:0] word, min_w, max_w, avg_w;

    mma_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .init(init), .step(step), .busy(busy), .done(done), .idx(idx)
    );

    mma_store #(.DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .busy(busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_idx(idx), .rd_word(word)
    );

    mma_reduce #(.DATA_W(DATA_W)) u_reduce (
        .clk(clk), .rst(rst), .init(init), .step(step), .word(word),
        .min_o(min_w), .max_o(max_w), .avg_o(avg_w)
    );

    always_comb begin
        unique case (rd_sel)
            SEL_MIN: rd_data = min_w;
            SEL_MAX: rd_data = max_w;
            SEL_AVG: rd_data = avg_w;
            default: rd_data = '0;
        endcase
    end

    // R4 and R5: a finished pass has minimum not above maximum
    p_min_le_max_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (min_w <= max_w));
endmodule

// File: tb/tb_mma_accum.sv
`timescale 1ns/1ps
module tb_mma_accum;
    localparam int W = 8;

    logic clk = 0, rst = 1, wr_en = 0, start = 0;
    logic [4:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0] rd_sel = 2'b00;
    logic done;
    logic [W-1:0] rd_data;

    mma_accum #(.DATA_W(W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .done(done),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    typedef struct { logic [W-1:0] mn, mx, av; } exp_t;
    exp_t sb_q[$];
    int total = 0, bad = 0;
    logic [W-1:0] shadow [32];
    logic reading = 0;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [W-1:0] v);
        @(negedge clk);
        wr_en = 1; wr_addr = 5'(a); wr_data = v;
        @(negedge clk);
        wr_en = 0;
        shadow[a] = v;
    endtask

    // driver: computes the expected results and queues them, then runs a pass
    task automatic run_pass(input bit poke_start, input bit poke_write);
        exp_t e;
        int sum = 0;
        e.mn = '1; e.mx = '0;
        for (int i = 0; i < 32; i++) begin
            sum += shadow[i];
            if (shadow[i] < e.mn) e.mn = shadow[i];
            if (shadow[i] > e.mx) e.mx = shadow[i];
        end
        e.av = W'(sum / 32);
        sb_q.push_back(e);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk("R8 done low after accepted start", {7'd0, done}, 8'd0);
        for (int k = 2; k <= 32; k++) begin
            @(negedge clk);
            if (poke_start && k == 10) start = 1;
            if (poke_start && k == 11) start = 0;
            if (poke_write && k >= 5 && k < 20) begin
                wr_en = 1; wr_addr = 5'(k); wr_data = ~shadow[k];
            end else wr_en = 0;
        end
        wr_en = 0;
        chk("R3 done still low one edge early", {7'd0, done}, 8'd0);
        @(negedge clk);
        chk(poke_start ? "R10 done on time despite start" : "R3 done on time",
            {7'd0, done}, 8'd1);
        wait (!reading);
        repeat (6) @(negedge clk);
        wait (!reading);
        chk("R8 done held", {7'd0, done}, 8'd1);
    endtask

    // monitor: pops the expected item and compares the three results
    initial begin
        exp_t e;
        forever begin
            @(posedge done);
            reading = 1;
            if (sb_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R3: done with no pass queued, got 1 expected 0");
            end else begin
                e = sb_q.pop_front();
                @(negedge clk); rd_sel = 2'b01; #1 chk("R4 minimum", rd_data, e.mn);
                @(negedge clk); rd_sel = 2'b10; #1 chk("R5 maximum", rd_data, e.mx);
                @(negedge clk); rd_sel = 2'b11; #1 chk("R6 average", rd_data, e.av);
                @(negedge clk); rd_sel = 2'b00; #1 chk("R7 select 00 zero", rd_data, '0);
            end
            reading = 0;
        end
    end

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] lfsr = 8'hA5;
        for (int i = 0; i < 32; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        @(negedge clk);
        chk("R1 done after reset", {7'd0, done}, 8'd0);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s); #1 chk("R1 result after reset", rd_data, '0);
        end
        // all zeros
        run_pass(0, 0);
        // all ones: the total reaches 32*255 with no wrap (R6), R2 stores
        for (int i = 0; i < 32; i++) put(i, 8'hFF);
        run_pass(0, 0);
        // ramp
        for (int i = 0; i < 32; i++) put(i, W'(i * 7 + 3));
        run_pass(0, 0);
        // scattered values from an LFSR
        for (int i = 0; i < 32; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            put(i, lfsr);
        end
        run_pass(0, 0);
        // extremes at first and last address, R11 fresh start
        for (int i = 0; i < 32; i++) put(i, 8'd200);
        put(0, 8'd250); put(31, 8'd5);
        run_pass(0, 0);
        // R6 truncation: total 31 gives 0, total 63 gives 1
        for (int i = 0; i < 32; i++) put(i, 8'd0);
        put(7, 8'd31);
        run_pass(0, 0);
        put(8, 8'd32);
        run_pass(0, 0);
        // R9 writes and R10 start during a pass are ignored
        for (int i = 0; i < 32; i++) put(i, W'(100 + i));
        run_pass(1, 1);
        run_pass(0, 0);
        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule